// File: doc/BRIEF.md
# Return Address Stack on Link Register

This block turns the link register (register x1) of a small RISC-style core into a hardware stack of return addresses. Each instruction presents three flags telling whether it names x1 as its first source, its second source or its destination, together with an instruction-valid strobe and the value it would write. Naming x1 as a source reads the top entry and removes it. Naming x1 as the destination places the write value on top. A call (jump-and-link into x1) therefore stores its return address. A return (indirect jump reading x1 and writing x0) consumes that address. An indirect call through another register that links into x1 does both jobs at once only when x1 is also a source. Otherwise it simply pushes.

Misuse is flagged instead of corrupting state. A source read of an empty stack is an error. A destination write to a full stack is also an error, but only when the same instruction does not also read x1, because a combined read and write leaves the depth unchanged. A failing instruction leaves the stack untouched. It produces a one-cycle error pulse and sets a sticky error flag that software-visible logic elsewhere clears with a strobe. The depth, empty and full status are always visible.

Top module: `link_stack`

## Requirements
- R1: A synchronous reset (`rstSync` high at a clock edge) empties the stack and clears both error outputs. After it, `depth` is 0, `stackEmpty` is 1, `stackFull` is 0 and `topData` is 0.
- R2: A valid instruction that names x1 as destination but not as any source pushes `wrData`, provided the stack is not full. After the edge, `topData` equals that value and `depth` has grown by one.
- R3: A valid instruction that names x1 as a source (first, second or both) and not as destination pops one entry, provided the stack is not empty. During that cycle `topData` shows the entry being read. After the edge, `depth` has dropped by exactly one, even when both sources name x1.
- R4: A valid instruction that names x1 both as a source and as the destination, on a non-empty stack, replaces the top entry with `wrData` and leaves `depth` unchanged. This holds also when the stack is full.
- R5: A valid instruction that names x1 as a source while the stack is empty raises `errPulse` for the cycle after its edge and changes neither `depth` nor stored entries. This applies even if it also names x1 as destination.
- R6: A valid instruction that names x1 as destination but not as a source while the stack holds `DEPTH` entries raises `errPulse` the cycle after its edge. The stack is left unchanged.
- R7: `errSticky` becomes 1 at the same edge that raises `errPulse` and stays 1 until an edge with `errClear` high and no new error. A new error wins over a clear in the same cycle.
- R8: When `instValid` is low, the operand flags and `wrData` have no effect on the stack or the error outputs.
- R9: `stackEmpty` is 1 exactly when `depth` is 0, and `stackFull` is 1 exactly when `depth` equals `DEPTH` (default 8).
- R10: Entries come back in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | The operand flags describe a real instruction this cycle |
| useRs1 | input | 1 | Instruction names x1 as first source |
| useRs2 | input | 1 | Instruction names x1 as second source |
| useRd | input | 1 | Instruction names x1 as destination |
| wrData | input | WIDTH | Value written to x1 (e.g. return address) |
| errClear | input | 1 | Clears the sticky error flag |
| topData | output | WIDTH | Current top entry, 0 when empty |
| errPulse | output | 1 | One-cycle misuse indication |
| errSticky | output | 1 | Held misuse flag |
| stackEmpty | output | 1 | No entries stored |
| stackFull | output | 1 | DEPTH entries stored |
| depth | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The hardest state to reach from the ports is a full stack meeting an instruction that reads and writes x1 together: this must replace the top entry, not raise an overflow error. Plain random stimulus seldom climbs to full, so the random mix is biased toward pushes in phases. A directed sequence also fills the stack, issues a replace, then a push that must overflow, before draining it in order and hitting the empty boundary with a combined read and write.

// File: rtl/link_stack_pkg.sv
package link_stack_pkg;

  // Strobes from the control to the datapath, already gated by errors and reset.
  typedef struct packed {
    logic push;     // store wrData above current top
    logic pop;      // drop top entry
    logic replace;  // overwrite top entry in place
  } stackStrobe_t;

endpackage

// File: rtl/link_stack_ctrl.sv
module link_stack_ctrl
  import link_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstSync,
  input  logic             instValid,
  input  logic             useRs1,
  input  logic             useRs2,
  input  logic             useRd,
  input  logic             errClear,
  output stackStrobe_t     strb,
  output logic [CNT_W-1:0] occ,
  output logic             errPulse,
  output logic             errSticky,
  output logic             stackEmpty,
  output logic             stackFull
);

  logic popReq, pushReq;
  logic underflow, overflow, anyErr;

  assign popReq     = instValid & (useRs1 | useRs2);
  assign pushReq    = instValid & useRd;
  assign stackEmpty = (occ == '0);
  assign stackFull  = (occ == CNT_W'(DEPTH));

  // Read of an empty stack always fails; a write only fails on full when
  // the same instruction does not also consume an entry.
  assign underflow = popReq & stackEmpty;
  assign overflow  = pushReq & ~popReq & stackFull;
  assign anyErr    = underflow | overflow;

  always_comb begin
    strb         = '0;
    strb.push    = pushReq & ~popReq & ~anyErr & ~rstSync;
    strb.pop     = popReq & ~pushReq & ~anyErr & ~rstSync;
    strb.replace = popReq & pushReq & ~anyErr & ~rstSync;
  end

  always_ff @(posedge clk) begin
    if (rstSync) begin
      occ       <= '0;
      errPulse  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      errPulse <= anyErr;
      if (anyErr)        errSticky <= 1'b1;
      else if (errClear) errSticky <= 1'b0;
      if (strb.push)     occ <= occ + CNT_W'(1);
      else if (strb.pop) occ <= occ - CNT_W'(1);
    end
  end

  // R5: source read of an empty stack reports and leaves depth alone
  p_underflow_r5: assert property (@(posedge clk) disable iff (rstSync)
    (instValid && (useRs1 || useRs2) && stackEmpty) |=> (errPulse && occ == '0));

  // R6: destination write to a full stack without a source read is refused
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rstSync)
    (instValid && useRd && !useRs1 && !useRs2 && stackFull) |=> (errPulse && stackFull));

  // R4: combined read and write keeps the depth
  p_replace_depth_r4: assert property (@(posedge clk) disable iff (rstSync)
    (instValid && useRd && (useRs1 || useRs2) && !stackEmpty) |=> ($stable(occ) && !errPulse));

  // R7: sticky flag holds without a clear
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rstSync)
    (errSticky && !errClear) |=> errSticky);

  // R8: idle cycles touch nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (rstSync)
    (!instValid) |=> ($stable(occ) && !errPulse));

  // R9: depth never exceeds capacity
  p_bound_r9: assert property (@(posedge clk) disable iff (rstSync)
    occ <= CNT_W'(DEPTH));

endmodule

// File: rtl/link_stack_dp.sv
module link_stack_dp
  import link_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstSync,
  input  stackStrobe_t     strb,
  input  logic [CNT_W-1:0] occ,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] topData
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IDX_W-1:0] topIdx, nextIdx;

  assign topIdx  = IDX_W'(occ - CNT_W'(1));
  assign nextIdx = IDX_W'(occ);

  // Entries need no reset: the occupancy count decides what is valid.
  always_ff @(posedge clk) begin
    if (strb.push)         mem[nextIdx] <= wrData;
    else if (strb.replace) mem[topIdx]  <= wrData;
  end

  assign topData = (occ == '0) ? '0 : mem[topIdx];

  // R2 / R4: a written value is visible on top after the edge
  p_write_visible_r2: assert property (@(posedge clk) disable iff (rstSync)
    (strb.push || strb.replace) |=> (topData == $past(wrData)));

  // Strobes are mutually exclusive
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (rstSync)
    $onehot0({strb.push, strb.pop, strb.replace}));

endmodule

// File: rtl/link_stack.sv
module link_stack
  import link_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic                         clk,
  input  logic                         rstSync,
  input  logic                         instValid,
  input  logic                         useRs1,
  input  logic                         useRs2,
  input  logic                         useRd,
  input  logic [WIDTH-1:0]             wrData,
  input  logic                         errClear,
  output logic [WIDTH-1:0]             topData,
  output logic                         errPulse,
  output logic                         errSticky,
  output logic                         stackEmpty,
  output logic                         stackFull,
  output logic [$clog2(DEPTH+1)-1:0]   depth
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  stackStrobe_t     strb;
  logic [CNT_W-1:0] occ;

  link_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstSync, .instValid, .useRs1, .useRs2, .useRd, .errClear,
    .strb, .occ, .errPulse, .errSticky, .stackEmpty, .stackFull
  );

  link_stack_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk, .rstSync, .strb, .occ, .wrData, .topData
  );

  assign depth = occ;

  // R1: reset leaves an empty stack without errors
  p_reset_empty_r1: assert property (@(posedge clk)
    rstSync |=> (depth == '0 && !errPulse && !errSticky && topData == '0));

endmodule

// File: tb/link_stack_tb.sv
`timescale 1ns/1ps
module link_stack_tb;
  localparam int DEPTH = 8;
  localparam int WIDTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rstSync = 1, instValid = 0, useRs1 = 0, useRs2 = 0, useRd = 0, errClear = 0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] topData;
  logic errPulse, errSticky, stackEmpty, stackFull;
  logic [CNT_W-1:0] depth;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [WIDTH-1:0] mdl [DEPTH];
  int mCnt = 0;
  bit mSticky = 0, mPulse = 0;

  always #2.5 clk = ~clk;

  link_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk, .rstSync, .instValid, .useRs1, .useRs2, .useRd, .wrData, .errClear,
    .topData, .errPulse, .errSticky, .stackEmpty, .stackFull, .depth
  );

  function automatic logic [WIDTH-1:0] expTop();
    return (mCnt == 0) ? '0 : mdl[mCnt-1];
  endfunction

  task automatic chk(input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(topData, expTop(), {tag, " top"});
    chk(WIDTH'(depth), WIDTH'(mCnt), {tag, " depth"});
    chk(WIDTH'(errPulse), WIDTH'(mPulse), {tag, " errPulse"});
    chk(WIDTH'(errSticky), WIDTH'(mSticky), {tag, " errSticky"});
    chk(WIDTH'(stackEmpty), WIDTH'(mCnt == 0), "R9 empty");
    chk(WIDTH'(stackFull), WIDTH'(mCnt == DEPTH), "R9 full");
  endtask

  task automatic step(input bit v, input bit a, input bit b, input bit d,
                      input logic [WIDTH-1:0] data, input bit clr, input string tag);
    bit pop, push, e;
    @(negedge clk);
    chk(topData, expTop(), {tag, " read-before"});
    instValid = v; useRs1 = a; useRs2 = b; useRd = d; wrData = data; errClear = clr;
    @(posedge clk);
    #1;
    pop  = v && (a || b);
    push = v && d;
    e = (pop && mCnt == 0) || (push && !pop && mCnt == DEPTH);
    mPulse = e;
    if (e) mSticky = 1;
    else if (clr) mSticky = 0;
    if (!e) begin
      if (pop && push) mdl[mCnt-1] = data;
      else if (push) begin mdl[mCnt] = data; mCnt++; end
      else if (pop) mCnt--;
    end
    checkAll(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstSync = 1; instValid = 0; errClear = 0;
    @(posedge clk); @(posedge clk); #1;
    mCnt = 0; mSticky = 0; mPulse = 0;
    checkAll("R1");
    @(negedge clk);
    rstSync = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    doReset();
    // Directed: fill with calls
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 1, 32'h1000 + 4 * i, 0, "R2");
    step(1, 1, 0, 1, 32'hAAAA_0000, 0, "R4");      // replace at full
    step(1, 0, 0, 1, 32'hBAD0_0001, 0, "R6");      // overflow
    step(1, 0, 0, 0, 32'h0, 0, "R7");              // sticky holds
    step(0, 1, 1, 1, 32'hDEAD_BEEF, 1, "R8");      // invalid instr: flags ignored, clear taken
    step(0, 1, 0, 0, 32'h0, 0, "R8");
    step(1, 1, 1, 0, 32'h0, 0, "R3");              // both sources: single pop
    for (int i = 0; i < DEPTH - 1; i++) step(1, i[0], !i[0], 0, 32'h0, 0, "R10");
    step(1, 1, 0, 1, 32'h7777_0000, 1, "R5");      // underflow with push, error beats clear
    step(1, 0, 1, 0, 32'h0, 0, "R5");
    step(1, 0, 0, 0, 32'h0, 1, "R7");              // clear
    doReset();
    // Random phases, biased toward pushes then pops
    for (int n = 0; n < 4000; n++) begin
      int r, bias;
      bit v, a, b, d, clr;
      string tag;
      bias = ((n / 200) % 2 == 0) ? 7 : 3;
      r = int'($urandom % 10);
      v = ($urandom % 8) != 0;
      a = 0; b = 0; d = 0;
      if (r < bias) d = 1;
      else if (r < 9) begin a = $urandom % 2; b = !a || ($urandom % 2); end
      else begin d = 1; a = 1; b = $urandom % 2; end
      clr = ($urandom % 6) == 0;
      if (!v) tag = "R8";
      else if ((a || b) && mCnt == 0) tag = "R5";
      else if (d && !(a || b) && mCnt == DEPTH) tag = "R6";
      else if (d && (a || b)) tag = "R4";
      else if (a || b) tag = "R3";
      else tag = "R2";
      step(v, a, b, d, $urandom, clr, tag);
      if (n == 2500) doReset();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule